// File: doc/BRIEF.md
# Quad DAC Serial Frame Transmitter

This block is the host-side controller for a four-channel, 8-bit serial DAC. A client hands it one write request through a valid/ready handshake. The request holds a 2-bit channel number, a gain bit, an 8-bit code and an update flag. The block builds an 11-bit frame from these fields and shifts it out, most significant bit first, on a serial clock and data pair. The serial clock is derived from the system clock.

After the last bit, the block pulses the active-low latch strobe so the receiver captures the frame. If the update flag was set, it then pulses the active-low output-transfer strobe, which moves all latched values to the analog outputs together. Every output is registered. The serial clock idles low. One serial period is `2*DIV` system clocks.

Top module: `qdac_frame_tx`

## Requirements
- R1: After a synchronous reset, `ser_clk` is 0, `ser_load_n` and `ser_ldac_n` are 1, `ser_data` is 0, `busy` and `done` are 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` is 0 and `busy` is 1 until the sequence ends. A `req_valid` raised while busy has no effect on any output.
- R3: Counting from the accept edge, `ser_clk` stays low for `DIV` cycles. It then makes 11 high pulses of `DIV` cycles each, separated by low spans of `DIV` cycles, and stays low until the next request.
- R4: The frame is {channel[1:0], gain, code[7:0]}, with channel in bits 10:9, gain in bit 8 (1 selects x2) and code in bits 7:0. During the high phase of pulse j (j = 0..10), `ser_data` holds frame bit 10-j.
- R5: While busy, `ser_data` changes only in a cycle in which `ser_clk` rises. It is therefore stable across every falling edge and every low span. In idle it keeps its last value.
- R6: `ser_load_n` is high while shifting. It is low for exactly `DIV` cycles, starting `23*DIV` cycles after the accept edge, which leaves a low gap of `DIV` cycles after the last falling edge.
- R7: With the update flag set, `ser_ldac_n` is low for `DIV` cycles starting in the cycle in which `ser_load_n` returns high. With the flag clear, `ser_ldac_n` stays high.
- R8: `done` is a one-cycle pulse in the first idle cycle, at `24*DIV` cycles after the accept edge without update or `25*DIV` with update. In that cycle `req_ready` is already 1.
- R9: `ser_load_n` and `ser_ldac_n` are never low together, and `ser_clk` is low while either of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | 2 | Target channel, 0..3 |
| req_gain | input | 1 | 1 selects x2 gain |
| req_code | input | 8 | Output code |
| req_update | input | 1 | Follow the latch strobe with an output-transfer strobe |
| ser_clk | output | 1 | Serial clock, idles low; receiver samples on its falling edge |
| ser_data | output | 1 | Serial data, MSB first |
| ser_load_n | output | 1 | Active-low frame latch strobe |
| ser_ldac_n | output | 1 | Active-low output-transfer strobe |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A wrong half-period index or timer count shows at the ports within one half serial period. It appears as a `ser_clk` edge off by a cycle, a missing or extra pulse, or strobes that start early or late. A fault in the shift register shows as a wrong `ser_data` value in the high phase of the affected bit. A wrong stored update flag shows as a missing or spurious `ser_ldac_n` pulse, and as `done` arriving `DIV` cycles early or late. The reference model is compared on every cycle, so each of these faults is reported in the first cycle in which it differs.

// File: rtl/qdac_pkg.sv
// Package: shared constants, sequencer state type and frame packing for the
// quad DAC serial frame transmitter.
// Assumes: 2-bit channel, 1 gain bit and 8-bit code, as the receiver expects.
package qdac_pkg;

    localparam int CHAN_W     = 2;
    localparam int CODE_W     = 8;
    localparam int FRAME_BITS = CHAN_W + 1 + CODE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_XFER  = 2'd3
    } seq_state_t;

    // Builds the transmitted word, channel in the top bits, code at the bottom.
    function automatic logic [FRAME_BITS-1:0] pack_frame(
        input logic [CHAN_W-1:0] chan,
        input logic              gain,
        input logic [CODE_W-1:0] code
    );
        return {chan, gain, code};
    endfunction

endpackage

// File: rtl/qdac_phase_timer.sv
// Module: counts the system clocks of one half serial period and flags the
// last one.
// Assumes: DIV >= 1. The counter is held at zero while not running, so each
// sequence starts from a full half period.
module qdac_phase_timer #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Half-period counter: wraps after DIV cycles, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!running || cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = running && (cnt == CNT_LAST);

    // R3: the half-period count never passes its last value.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: rtl/qdac_frame_shifter.sv
// Module: holds the frame being sent and presents its MSB as serial data.
// Assumes: load_en and shift_en are never high together. A shift happens only
// on the system edge where the serial clock rises.
module qdac_frame_shifter #(
    parameter int BITS = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [BITS-1:0] load_word,
    input  logic            shift_en,
    output logic            data_out
);
    logic [BITS-1:0] shreg;

    // Shift register: load on accept, move one place toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg <= load_word;
        end else if (shift_en) begin
            shreg <= {shreg[BITS-2:0], 1'b0};
        end
    end

    assign data_out = shreg[BITS-1];

    // R5: loading and shifting never coincide.
    assert_no_load_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && shift_en));

endmodule

// File: rtl/qdac_sequencer.sv
// Module: state machine that runs the serial clock through 11 pulses plus a
// trailing gap, then the latch strobe and the optional transfer strobe.
// Assumes: tick marks the last cycle of every half period while not idle.
// All serial outputs are registered.
module qdac_sequencer #(
    parameter int BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic update_in,
    input  logic tick,
    output logic running,
    output logic shift_en,
    output logic ready,
    output logic ser_clk,
    output logic ser_load_n,
    output logic ser_ldac_n,
    output logic done
);
    import qdac_pkg::*;

    localparam int HALF_N = 2 * BITS + 1;
    localparam int H_W    = $clog2(HALF_N);
    localparam logic [H_W-1:0] H_LAST  = H_W'(HALF_N - 1);
    localparam logic [H_W-1:0] H_FIRST = H_W'(2);

    seq_state_t     state;
    logic [H_W-1:0] half_idx;
    logic           upd_q;
    logic           clk_q;
    logic           load_q;
    logic           ldac_q;
    logic           done_q;

    // Main sequencer: advances one half period per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            half_idx <= '0;
            upd_q    <= 1'b0;
            clk_q    <= 1'b0;
            load_q   <= 1'b1;
            ldac_q   <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_SHIFT;
                        half_idx <= '0;
                        upd_q    <= update_in;
                        clk_q    <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (half_idx == H_LAST) begin
                            state  <= ST_LOAD;
                            load_q <= 1'b0;
                            clk_q  <= 1'b0;
                        end else begin
                            half_idx <= half_idx + 1'b1;
                            clk_q    <= ~half_idx[0];
                        end
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        load_q <= 1'b1;
                        if (upd_q) begin
                            state  <= ST_XFER;
                            ldac_q <= 1'b0;
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        ldac_q <= 1'b1;
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Shift on the edge entering pulse 1..10, so data moves with a rising edge.
    assign shift_en = (state == ST_SHIFT) && tick && !half_idx[0]
                      && (half_idx >= H_FIRST) && (half_idx < H_LAST);

    assign running    = (state != ST_IDLE);
    assign ready      = (state == ST_IDLE);
    assign ser_clk    = clk_q;
    assign ser_load_n = load_q;
    assign ser_ldac_n = ldac_q;
    assign done       = done_q;

    // R9: the two strobes never overlap.
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ser_load_n && !ser_ldac_n));

    // R9: the serial clock is low during any strobe.
    assert_clk_low_in_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_load_n || !ser_ldac_n) |-> !ser_clk);

    // R6: the latch strobe starts after at least one low cycle of the clock.
    assert_load_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_load_n) |-> (!ser_clk && !$past(ser_clk)));

    // R7: the transfer strobe starts exactly as the latch strobe ends.
    assert_ldac_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_ldac_n) |-> $rose(ser_load_n));

    // R8: done lasts one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an accepted request takes the ready signal away next cycle.
    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

endmodule

// File: rtl/qdac_frame_tx.sv
// Module: top of the quad DAC serial frame transmitter. Accepts one request
// per transfer, serializes the 11-bit frame, then issues the latch strobe and
// the optional transfer strobe.
// Assumes: DIV system clocks per half serial period, DIV >= 1.
module qdac_frame_tx #(
    parameter int DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_chan,
    input  logic       req_gain,
    input  logic [7:0] req_code,
    input  logic       req_update,
    output logic       ser_clk,
    output logic       ser_data,
    output logic       ser_load_n,
    output logic       ser_ldac_n,
    output logic       busy,
    output logic       done
);
    import qdac_pkg::*;

    logic accept;
    logic running;
    logic tick;
    logic shift_en;
    logic ready_w;
    logic [FRAME_BITS-1:0] frame_w;

    assign accept    = req_valid && ready_w;
    assign frame_w   = pack_frame(req_chan, req_gain, req_code);
    assign req_ready = ready_w;
    assign busy      = running;

    qdac_phase_timer #(.DIV(DIV)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .tick    (tick)
    );

    qdac_frame_shifter #(.BITS(FRAME_BITS)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .load_word (frame_w),
        .shift_en  (shift_en),
        .data_out  (ser_data)
    );

    qdac_sequencer #(.BITS(FRAME_BITS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .update_in  (req_update),
        .tick       (tick),
        .running    (running),
        .shift_en   (shift_en),
        .ready      (ready_w),
        .ser_clk    (ser_clk),
        .ser_load_n (ser_load_n),
        .ser_ldac_n (ser_ldac_n),
        .done       (done)
    );

    // R5: while busy, data moves only together with a rising serial clock.
    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$rose(ser_clk)) |-> $stable(ser_data));

endmodule

// File: tb/qdac_frame_tx_tb_top.sv
// Bench: behavioural reference model (cycle count since accept) compared
// against every output on every falling clock edge.
module qdac_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_chan = '0;
    logic       req_gain = 1'b0;
    logic [7:0] req_code = '0;
    logic       req_update = 1'b0;
    logic       ser_clk, ser_data, ser_load_n, ser_ldac_n, busy, done;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    bit        m_busy = 1'b0;
    bit        m_done = 1'b0;
    bit        m_upd  = 1'b0;
    bit        m_last = 1'b0;
    bit [10:0] m_frame = '0;
    int        m_t = 0;
    bit        started = 1'b0;
    bit        prev_clk = 1'b0;
    bit        prev_data = 1'b0;
    bit        prev_busy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_frame_tx #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_gain(req_gain), .req_code(req_code),
        .req_update(req_update), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load_n(ser_load_n), .ser_ldac_n(ser_ldac_n), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // Model update on each active edge, from the inputs held stable around it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_last = 1'b0; started = 1'b1;
        end else if (!m_busy) begin
            m_done = 1'b0;
            if (req_valid) begin
                m_busy  = 1'b1;
                m_t     = 0;
                m_frame = {req_chan, req_gain, req_code};
                m_upd   = req_update;
            end
        end else begin
            m_t++;
            if (m_t == (m_upd ? 25 : 24) * DIV) begin
                m_busy = 1'b0;
                m_done = 1'b1;
                m_last = m_frame[0];
            end
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            int  p;
            int  idx;
            bit  e_clk, e_data, e_load, e_ldac;
            if (m_busy) begin
                p = m_t / DIV;
                if (p == 0) idx = 10;
                else if (p <= 21) idx = 10 - ((p - 1) / 2);
                else idx = 0;
                e_clk  = (p < 23) && (p % 2 == 1);
                e_data = m_frame[idx];
                e_load = (p != 23);
                e_ldac = (p != 24);
            end else begin
                e_clk = 1'b0; e_data = m_last; e_load = 1'b1; e_ldac = 1'b1;
            end
            chk("R2", "req_ready", req_ready, !m_busy);
            chk("R2", "busy", busy, m_busy);
            chk("R3", "ser_clk", ser_clk, e_clk);
            chk("R4", "ser_data", ser_data, e_data);
            chk("R6", "ser_load_n", ser_load_n, e_load);
            chk("R7", "ser_ldac_n", ser_ldac_n, e_ldac);
            chk("R8", "done", done, m_done);
            if (rst_n && prev_busy && busy && !(ser_clk && !prev_clk))
                chk("R5", "data stable", ser_data, prev_data);
            chk("R9", "strobes exclusive", !ser_load_n && !ser_ldac_n, 1'b0);
            prev_clk  = ser_clk;
            prev_data = ser_data;
            prev_busy = busy;
        end
    end

    task automatic send(input logic [1:0] ch, input logic g, input logic [7:0] code, input logic upd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_chan = ch; req_gain = g; req_code = code; req_update = upd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset ser_clk", ser_clk, 1'b0);
        chk("R1", "reset ser_load_n", ser_load_n, 1'b1);
        chk("R1", "reset ser_ldac_n", ser_ldac_n, 1'b1);
        chk("R1", "reset ser_data", ser_data, 1'b0);
        chk("R1", "reset busy", busy, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        chk("R1", "reset req_ready", req_ready, 1'b1);

        // R4 patterns across channels, gains and codes; R7 with and without update
        send(2'd0, 1'b0, 8'h00, 1'b0); wait_idle();
        send(2'd3, 1'b1, 8'hFF, 1'b1); wait_idle();
        send(2'd1, 1'b0, 8'hA5, 1'b1); wait_idle();
        send(2'd2, 1'b1, 8'h5A, 1'b0);
        // R2: a request offered while busy must change nothing
        repeat (5) @(negedge clk);
        req_chan = 2'd1; req_gain = 1'b1; req_code = 8'h3C; req_update = 1'b1;
        req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        // R8: back-to-back, request held so it is taken in the done cycle
        req_chan = 2'd3; req_gain = 1'b0; req_code = 8'h81; req_update = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        while (!done) @(negedge clk);
        req_chan = 2'd0; req_gain = 1'b1; req_code = 8'h7E; req_update = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule